// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a free-running 16-bit up-counter whose count enable comes from a selectable prescaler. A three-bit select field picks a power-of-two division of the bus clock, from one to sixty-four, or switches the count source to rising edges on an external clock input. The external input is synchronised before its edges are detected.

Software sees the block through an 8-bit register bus with single-cycle read and write strobes. There is one control/status byte and two read-only counter bytes. Reading the upper byte freezes a copy of the lower byte, so a two-byte read stays coherent while the counter keeps running. The control byte has these fields: a stop bit, a self-clearing counter-clear bit, the prescaler select, and a sticky overflow flag. The overflow flag is also driven on an output pin.

Top module: `tick_timer16`

## Requirements
- R1: After system reset, the control byte at offset 0x20 reads 0x00, the overflow output is 0, and the counter starts from 0x0000 at divide-by-1.
- R2: The select field in control bits 2:0 sets the count rate. A value k from 0 to 6 advances the counter once every 2^k bus clocks. After a counter clear, the counter holds floor(n / 2^k) once n clocks have elapsed.
- R3: When the counter advances from 0xFFFF, it wraps to 0x0000 and sets the sticky overflow flag. The flag reads in control bit 7 and also drives the overflow output.
- R4: A control write with bit 7 at 0 clears the overflow flag. A control write with bit 7 at 1 leaves the flag as it is.
- R5: A bus read of offset 0x21 returns counter bits 15:8 and captures counter bits 7:0 into a holding byte. The next read of offset 0x22 returns that holding byte. Further reads of 0x21 in between do not refresh the holding byte.
- R6: A read of offset 0x22 with no capture pending returns the live counter bits 7:0.
- R7: A control write with bit 4 at 1 clears the counter and the prescaler, and counting resumes from 0x0000. Bit 4 always reads 0. The stop bit and the select field take the written values as on any other control write.
- R8: While control bit 5 (stop) is 1, the counter holds its value. A single write that sets both bit 5 and bit 4 holds the counter at 0x0000.
- R9: With select value 7, the counter advances once per rising edge of the external clock input, after that input passes a two-flop synchroniser.
- R10: Reads of any address other than 0x20, 0x21 and 0x22 return 0x00. Writes to 0x21 and 0x22 have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_clk_in | input | 1 | Asynchronous external count clock |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a three-bit select field, a two-stage synchroniser and a base address of 0x20. With a full 16-bit counter at divide-by-1, the wrap and the overflow flag come into reach after about 65,540 cycles. The divide settings 2 to 64 are each run long enough that both counter bytes carry non-trivial values. A counter that advances every cycle between the high-byte read and the low-byte read makes the holding byte visibly differ from the live low byte.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = 2 * BYTE_W;
  localparam int SEL_W    = 3;
  localparam int PRE_W    = (1 << SEL_W) - 2;
  localparam int SYNC_N   = 2;

  localparam int BIT_OVF  = 7;
  localparam int BIT_STOP = 5;
  localparam int BIT_CLR  = 4;

  // Low-bit mask of the prescaler counter: its bits are all ones once every 2^sel cycles.
  function automatic logic [PRE_W-1:0] pre_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_byte(input logic ovf, input logic stop,
                                                  input logic [SEL_W-1:0] sel);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[BIT_OVF]     = ovf;
    b[BIT_STOP]    = stop;
    b[SEL_W-1:0]   = sel;
    return b;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int PW = PRE_W,
  parameter int SN = SYNC_N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [SW-1:0] sel,
  input  logic          ext_in,
  output logic          tick
);
  localparam logic [SW-1:0] EXT_SEL = '1;

  logic [SN-1:0] sync_q;
  logic          ext_d;
  logic          ext_rise;
  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      ext_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SN-2:0], ext_in};
      ext_d  <= sync_q[SN-1];
    end
  end

  assign ext_rise = sync_q[SN-1] & ~ext_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end

  assign mask = PW'(pre_mask(SEL_W'(sel)));
  assign tick = (sel == EXT_SEL) ? ext_rise : ((pre_q & mask) == mask);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  assign wrap = adv & ~clr & (cnt == '1);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap,
  output logic              stop,
  output logic              clr,
  output logic [SEL_W-1:0]  sel,
  output logic              ovf,
  output logic              lat_valid,
  output logic [BYTE_W-1:0] lat_buf
);
  localparam logic [BYTE_W-1:0] A_CTRL = BASE;
  localparam logic [BYTE_W-1:0] A_HI   = BASE + 8'd1;
  localparam logic [BYTE_W-1:0] A_LO   = BASE + 8'd2;

  logic hit_ctrl, hit_hi, hit_lo, wr_ctrl;

  assign hit_ctrl = (bus_addr == A_CTRL);
  assign hit_hi   = (bus_addr == A_HI);
  assign hit_lo   = (bus_addr == A_LO);
  assign wr_ctrl  = bus_wr & hit_ctrl;
  assign clr      = wr_ctrl & bus_wdata[BIT_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop <= 1'b0;
      sel  <= '0;
    end else if (wr_ctrl) begin
      stop <= bus_wdata[BIT_STOP];
      sel  <= bus_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ovf <= 1'b0;
    else if (wrap)                             ovf <= 1'b1;
    else if (wr_ctrl && !bus_wdata[BIT_OVF])   ovf <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_valid <= 1'b0;
      lat_buf   <= '0;
    end else if (bus_rd && hit_hi && !lat_valid) begin
      lat_valid <= 1'b1;
      lat_buf   <= cnt[BYTE_W-1:0];
    end else if (bus_rd && hit_lo) begin
      lat_valid <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl)    bus_rdata = ctrl_byte(ovf, stop, sel);
      else if (hit_hi) bus_rdata = cnt[CNT_W-1:BYTE_W];
      else if (hit_lo) bus_rdata = lat_valid ? lat_buf : cnt[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
  import tick_timer_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk_in,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ovf_flag
);
  logic [CNT_W-1:0]  cnt;
  logic              tick, adv, wrap, stop, clr, ovf, lat_valid;
  logic [SEL_W-1:0]  sel;
  logic [BYTE_W-1:0] lat_buf;

  assign adv      = tick & ~stop;
  assign ovf_flag = ovf;

  tick_prescaler #(.SW(SEL_W), .PW(PRE_W), .SN(SYNC_N)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(~stop), .clr(clr), .sel(sel),
    .ext_in(ext_clk_in), .tick(tick)
  );

  tick_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .cnt(cnt), .wrap(wrap)
  );

  tick_regs #(.BASE(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .wrap(wrap), .stop(stop), .clr(clr), .sel(sel), .ovf(ovf),
    .lat_valid(lat_valid), .lat_buf(lat_buf)
  );
endmodule

// File: rtl/tick_timer16_chk.sv
module tick_timer16_chk #(
  parameter int CW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          tick,
  input logic          stop,
  input logic          clr,
  input logic          ovf_flag,
  input logic          lat_valid,
  input logic [BW-1:0] lat_buf,
  input logic          bus_rd,
  input logic [7:0]    bus_addr,
  input logic [7:0]    bus_rdata,
  input logic [7:0]    base
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !clr && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && !clr && cnt == '1) |=> (cnt == '0 && ovf_flag));

  p_hold_buf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_valid && !(bus_rd && bus_addr == base + 8'd2)) |=> (lat_valid && $stable(lat_buf)));

  p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  p_clr_reads0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == base) |-> !bus_rdata[4]);

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !clr) |=> $stable(cnt));
endmodule

bind tick_timer16 tick_timer16_chk #(.CW(tick_timer_pkg::CNT_W), .BW(tick_timer_pkg::BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .tick(tick), .stop(stop), .clr(clr),
  .ovf_flag(ovf_flag), .lat_valid(lat_valid), .lat_buf(lat_buf),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .base(BASE_ADDR)
);

// File: tb/tick_timer16_bench.sv
module tick_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ovf_flag;

  int errors = 0;
  int checks = 0;
  longint edges = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // model state
  longint      e0 = 0;
  int          ps = 0;
  bit          stopped = 0;
  logic [15:0] frozen = '0;
  logic [7:0]  held_lo = '0;

  tick_timer16 u_tick_timer16 (
    .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_flag(ovf_flag)
  );

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // monitor: pops expected read data and compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (bus_rd) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: actual=%02h expected=<none>", bus_rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  function automatic logic [15:0] model_cnt();
    if (stopped) return frozen;
    return 16'((edges - e0) >> ps);
  endfunction

  task automatic check_direct(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    bus_write(8'h20, d);
    if (d[5]) begin
      frozen  = d[4] ? 16'h0 : model_cnt();
      stopped = 1;
    end else begin
      stopped = 0;
    end
    if (d[4]) e0 = edges;
    ps = int'(d[2:0]);
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_hi(input string tag);
    logic [15:0] v;
    @(negedge clk);
    v = model_cnt();
    held_lo = v[7:0];
    bus_addr = 8'h21; bus_rd = 1'b1;
    exp_q.push_back(v[15:8]);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic read_pair(input string tag);
    read_hi(tag);
    bus_read(8'h22, held_lo, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e0 = edges;

    // R1: reset state
    bus_read(8'h20, 8'h00, "R1 ctrl after reset");
    read_pair("R1 counter after reset");
    check_direct("R1 ovf_flag after reset", {7'b0, ovf_flag}, 8'h00);

    // R2: every divide setting
    for (int k = 0; k < 7; k++) begin
      ctrl_write(8'h10 | 8'(k));
      repeat (300 + 97 * k) @(negedge clk);
      read_pair($sformatf("R2 divide 2^%0d", k));
    end

    // R5: repeated high reads keep the first capture
    ctrl_write(8'h10);
    repeat (700) @(negedge clk);
    read_hi("R5 first high read");
    begin
      logic [7:0] keep;
      keep = held_lo;
      repeat (5) @(negedge clk);
      read_hi("R5 second high read");
      bus_read(8'h22, keep, "R5 low returns first capture");
    end

    // R6: low read with nothing captured is live
    repeat (3) @(negedge clk);
    begin
      logic [15:0] v;
      @(negedge clk);
      v = model_cnt();
      bus_addr = 8'h22; bus_rd = 1'b1;
      exp_q.push_back(v[7:0]); tag_q.push_back("R6 live low read");
      @(negedge clk);
      bus_rd = 1'b0;
    end

    // R7: clear while running, other fields follow the write, bit 4 reads 0
    repeat (50) @(negedge clk);
    ctrl_write(8'h13);
    bus_read(8'h20, 8'h03, "R7 ctrl after clear write");
    repeat (40) @(negedge clk);
    read_pair("R7 count resumes from zero");

    // R8: stop holds the count, stop with clear holds zero
    ctrl_write(8'h22);
    repeat (30) @(negedge clk);
    read_pair("R8 stopped count held");
    bus_read(8'h20, 8'h22, "R8 ctrl stop field");
    ctrl_write(8'h30);
    repeat (25) @(negedge clk);
    read_pair("R8 stop with clear holds zero");

    // R10: decode
    bus_write(8'h21, 8'hFF);
    bus_write(8'h22, 8'hFF);
    read_pair("R10 writes to counter bytes ignored");
    bus_read(8'h23, 8'h00, "R10 unmapped 0x23");
    bus_read(8'h1F, 8'h00, "R10 unmapped 0x1F");

    // R9: external clock edges
    ctrl_write(8'h17);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk); ext_clk_in = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    bus_read(8'h21, 8'h00, "R9 external high byte");
    bus_read(8'h22, 8'h05, "R9 external edge count");

    // R3 / R4: wrap and overflow flag
    ctrl_write(8'h10);
    repeat (65540) @(negedge clk);
    bus_read(8'h20, 8'h80, "R3 overflow flag set");
    check_direct("R3 ovf_flag output", {7'b0, ovf_flag}, 8'h01);
    read_pair("R3 counter wrapped");
    bus_write(8'h20, 8'h80);
    bus_read(8'h20, 8'h80, "R4 write 1 keeps flag");
    bus_write(8'h20, 8'h00);
    bus_read(8'h20, 8'h00, "R4 write 0 clears flag");
    check_direct("R4 ovf_flag output cleared", {7'b0, ovf_flag}, 8'h00);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule